// File: doc/BRIEF.md
# Multi-Issue Group Hazard Checker

This block sits in the decode stage of an in-order superscalar pipeline. Each cycle it looks at a group of up to four decoded instructions and decides how many of them, counted from the oldest slot, may go forward together. Every slot supplies a valid bit, two source register indices with use flags, a destination index with a write flag, and a two-bit class code. A side input carries the destination of the load that issued in the previous cycle.

Issue stops at the first slot that has a problem. A slot has a problem when it is invalid, when it reads a register that an older slot of the same group writes, when it reads the register that last cycle's load is still producing, or when it would be a second load or a second divide in the group. The result is a registered count of the leading slots that issue. The front end presents the held instructions again on the next cycle, in the same order.

Top module: `issue_group_checker`

## Requirements
- R1: `issueCount` is a register. It is 0 while `rstN` is low, and otherwise it takes, at each rising clock edge, the count computed from the inputs sampled at that edge.
- R2: The count is the number of leading slots that issue, from 0 to WIDTH. An invalid slot issues nothing and stops the count at its own position.
- R3: A slot is blocked when one of its used sources equals the destination of any older slot in the same group. Each later slot compares both of its sources with every older destination.
- R4: A source/destination match counts only when the producer's write flag and the consumer's use flag are both set. Register index 0 never creates a dependence.
- R5: A slot is blocked when a used, nonzero source equals `prevLoadDst` while `prevLoadValid` is high. This rule applies to slot 0 as well.
- R6: Class codes are ALU=0, load=1, store=2, divide=3. Only one load issues per group, so the second load in a group is blocked.
- R7: Only one divide issues per group, so the second divide is blocked. ALU and store slots have no per-group limit.
- R8: A valid slot 0 always issues unless the load-use rule (R5) blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotValid | input | WIDTH | Per-slot valid; bit 0 is the oldest slot |
| srcAIdx | input | WIDTH*REG_BITS | First source index per slot; slot s at bits s*REG_BITS upward |
| srcAUse | input | WIDTH | First source is read |
| srcBIdx | input | WIDTH*REG_BITS | Second source index per slot |
| srcBUse | input | WIDTH | Second source is read |
| dstIdx | input | WIDTH*REG_BITS | Destination index per slot |
| dstWr | input | WIDTH | Destination is written |
| slotClass | input | 2*WIDTH | Class code per slot (ALU=0, load=1, store=2, divide=3) |
| prevLoadValid | input | 1 | A load issued in the previous cycle |
| prevLoadDst | input | REG_BITS | Destination of that load |
| issueCount | output | CNT_W | Registered count of leading slots that issue |

## Verification
The checker assumes that every input is at a known two-state value at each rising edge. It also assumes that the prior-load fields describe one load at most, and that nothing else constrains the relation between them and the group. The bench changes inputs only on falling edges and draws register indices from a small range, so that matches, index-0 cases and load/divide pairs occur often. Directed groups cover the cases that random draws rarely produce: a fully clean group, a dependence that is masked by a cleared flag, and a load-use hit on slot 0.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_DIV   = 2'd3
  } insnClass_e;

  // Per-slot strobes handed from the comparator datapath to the count control
  typedef struct packed {
    logic valid;
    logic depStall;
    logic loadUse;
    logic isLoad;
    logic isDiv;
  } slotStrobe_t;

endpackage

// File: rtl/issue_hazard_dp.sv
module issue_hazard_dp
  import issue_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5
) (
  input  logic [WIDTH-1:0]          slotValid,
  input  logic [WIDTH*REG_BITS-1:0] srcAIdx,
  input  logic [WIDTH-1:0]          srcAUse,
  input  logic [WIDTH*REG_BITS-1:0] srcBIdx,
  input  logic [WIDTH-1:0]          srcBUse,
  input  logic [WIDTH*REG_BITS-1:0] dstIdx,
  input  logic [WIDTH-1:0]          dstWr,
  input  logic [2*WIDTH-1:0]        slotClass,
  input  logic                      prevLoadValid,
  input  logic [REG_BITS-1:0]       prevLoadDst,
  output slotStrobe_t [WIDTH-1:0]   strobes
);

  logic [REG_BITS-1:0] dstArr [WIDTH];
  logic [WIDTH-1:0]    dstLive;

  for (genvar p = 0; p < WIDTH; p++) begin : g_prod
    assign dstArr[p]  = dstIdx[p*REG_BITS +: REG_BITS];
    assign dstLive[p] = dstWr[p] && (dstArr[p] != '0);
  end

  for (genvar s = 0; s < WIDTH; s++) begin : g_slot
    logic [REG_BITS-1:0] regA;
    logic [REG_BITS-1:0] regB;
    logic                liveA;
    logic                liveB;
    logic [WIDTH-1:0]    pairHit;
    insnClass_e          cls;

    assign regA  = srcAIdx[s*REG_BITS +: REG_BITS];
    assign regB  = srcBIdx[s*REG_BITS +: REG_BITS];
    assign liveA = srcAUse[s] && (regA != '0);
    assign liveB = srcBUse[s] && (regB != '0);
    assign cls   = insnClass_e'(slotClass[2*s +: 2]);

    // Two comparators per older producer: 2, 6, 12 for groups of 2, 3, 4
    for (genvar j = 0; j < WIDTH; j++) begin : g_pair
      if (j < s) begin : g_older
        assign pairHit[j] = dstLive[j] &&
                            ((liveA && (regA == dstArr[j])) ||
                             (liveB && (regB == dstArr[j])));
      end else begin : g_none
        assign pairHit[j] = 1'b0;
      end
    end

    assign strobes[s].valid    = slotValid[s];
    assign strobes[s].depStall = |pairHit;
    assign strobes[s].loadUse  = prevLoadValid &&
                                 ((liveA && (regA == prevLoadDst)) ||
                                  (liveB && (regB == prevLoadDst)));
    assign strobes[s].isLoad   = (cls == CLS_LOAD);
    assign strobes[s].isDiv    = (cls == CLS_DIV);
  end

endmodule

// File: rtl/issue_count_ctrl.sv
module issue_count_ctrl
  import issue_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  slotStrobe_t [WIDTH-1:0] strobes,
  output logic [CNT_W-1:0]        issueCount
);

  // Prefix chain: a slot may go only if every older slot went
  logic [WIDTH:0] goChain;
  logic [WIDTH:0] loadTaken;
  logic [WIDTH:0] divTaken;
  logic [CNT_W-1:0] countNext;

  assign goChain[0]   = 1'b1;
  assign loadTaken[0] = 1'b0;
  assign divTaken[0]  = 1'b0;

  for (genvar s = 0; s < WIDTH; s++) begin : g_chain
    logic blocked;
    assign blocked = !strobes[s].valid || strobes[s].depStall ||
                     strobes[s].loadUse ||
                     (strobes[s].isLoad && loadTaken[s]) ||
                     (strobes[s].isDiv && divTaken[s]);
    assign goChain[s+1]   = goChain[s] && !blocked;
    assign loadTaken[s+1] = loadTaken[s] || strobes[s].isLoad;
    assign divTaken[s+1]  = divTaken[s] || strobes[s].isDiv;
  end

  always_comb begin
    countNext = '0;
    for (int k = 1; k <= WIDTH; k++) begin
      if (goChain[k]) countNext = CNT_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) issueCount <= '0;
    else       issueCount <= countNext;
  end

endmodule

// File: rtl/issue_group_checker.sv
module issue_group_checker
  import issue_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5,
  localparam int CNT_W   = $clog2(WIDTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [WIDTH-1:0]          slotValid,
  input  logic [WIDTH*REG_BITS-1:0] srcAIdx,
  input  logic [WIDTH-1:0]          srcAUse,
  input  logic [WIDTH*REG_BITS-1:0] srcBIdx,
  input  logic [WIDTH-1:0]          srcBUse,
  input  logic [WIDTH*REG_BITS-1:0] dstIdx,
  input  logic [WIDTH-1:0]          dstWr,
  input  logic [2*WIDTH-1:0]        slotClass,
  input  logic                      prevLoadValid,
  input  logic [REG_BITS-1:0]       prevLoadDst,
  output logic [CNT_W-1:0]          issueCount
);

  slotStrobe_t [WIDTH-1:0] strobes;

  issue_hazard_dp #(.WIDTH(WIDTH), .REG_BITS(REG_BITS)) i_dp (
    .slotValid    (slotValid),
    .srcAIdx      (srcAIdx),
    .srcAUse      (srcAUse),
    .srcBIdx      (srcBIdx),
    .srcBUse      (srcBUse),
    .dstIdx       (dstIdx),
    .dstWr        (dstWr),
    .slotClass    (slotClass),
    .prevLoadValid(prevLoadValid),
    .prevLoadDst  (prevLoadDst),
    .strobes      (strobes)
  );

  issue_count_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .issueCount(issueCount)
  );

endmodule

// File: rtl/issue_group_checker_sva.sv
module issue_group_checker_sva #(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5,
  localparam int CNT_W   = $clog2(WIDTH + 1)
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [WIDTH-1:0]              slotValid,
  input logic [WIDTH*REG_BITS-1:0]     srcAIdx,
  input logic [WIDTH-1:0]              srcAUse,
  input logic [(WIDTH-1)*REG_BITS-1:0] dstLow,
  input logic [WIDTH-2:0]              dstWrLow,
  input logic [2*WIDTH-1:0]            slotClass,
  input logic                          prevLoadValid,
  input logic [REG_BITS-1:0]           prevLoadDst,
  input logic [CNT_W-1:0]              issueCount
);

  // R2: count never exceeds the group width
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rstN)
    issueCount <= CNT_W'(WIDTH));

  // R8: forward progress when no earlier load is outstanding
  a_r8_slot0_progress: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid[0] && !prevLoadValid) |=> (issueCount != '0));

  for (genvar k = 0; k < WIDTH; k++) begin : g_slotChk
    // R2: an invalid slot caps the count at its position
    a_r2_invalid_caps: assert property (@(posedge clk) disable iff (!rstN)
      !slotValid[k] |=> (issueCount <= CNT_W'(k)));

    // R5: load-use hit on the first source stops issue at this slot
    a_r5_load_use: assert property (@(posedge clk) disable iff (!rstN)
      (prevLoadValid && srcAUse[k] &&
       (srcAIdx[k*REG_BITS +: REG_BITS] != '0) &&
       (srcAIdx[k*REG_BITS +: REG_BITS] == prevLoadDst))
      |=> (issueCount <= CNT_W'(k)));

    if (k > 0) begin : g_pairChk
      // R3: adjacent read-after-write inside the group
      a_r3_adjacent_raw: assert property (@(posedge clk) disable iff (!rstN)
        (dstWrLow[k-1] && (dstLow[(k-1)*REG_BITS +: REG_BITS] != '0) &&
         srcAUse[k] &&
         (srcAIdx[k*REG_BITS +: REG_BITS] == dstLow[(k-1)*REG_BITS +: REG_BITS]))
        |=> (issueCount <= CNT_W'(k)));

      // R6: two adjacent loads cannot both issue
      a_r6_one_load: assert property (@(posedge clk) disable iff (!rstN)
        ((slotClass[2*(k-1) +: 2] == 2'd1) && (slotClass[2*k +: 2] == 2'd1))
        |=> (issueCount <= CNT_W'(k)));

      // R7: two adjacent divides cannot both issue
      a_r7_one_div: assert property (@(posedge clk) disable iff (!rstN)
        ((slotClass[2*(k-1) +: 2] == 2'd3) && (slotClass[2*k +: 2] == 2'd3))
        |=> (issueCount <= CNT_W'(k)));
    end
  end

endmodule

bind issue_group_checker issue_group_checker_sva #(
  .WIDTH(WIDTH), .REG_BITS(REG_BITS)
) i_sva (
  .clk          (clk),
  .rstN         (rstN),
  .slotValid    (slotValid),
  .srcAIdx      (srcAIdx),
  .srcAUse      (srcAUse),
  .dstLow       (dstIdx[(WIDTH-1)*REG_BITS-1:0]),
  .dstWrLow     (dstWr[WIDTH-2:0]),
  .slotClass    (slotClass),
  .prevLoadValid(prevLoadValid),
  .prevLoadDst  (prevLoadDst),
  .issueCount   (issueCount)
);

// File: tb/test_issue_group_checker.sv
`timescale 1ns/1ps
module test_issue_group_checker;
  localparam int W  = 4;
  localparam int RB = 5;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] vld, useA, useB, wr;
  logic [RB-1:0] ra [W];
  logic [RB-1:0] rb [W];
  logic [RB-1:0] rd [W];
  logic [1:0]    cls [W];
  logic          plv;
  logic [RB-1:0] pld;

  logic [W*RB-1:0] srcAIdx, srcBIdx, dstIdx;
  logic [2*W-1:0]  slotClass;
  logic [CW-1:0]   issueCount;

  always_comb begin
    for (int s = 0; s < W; s++) begin
      srcAIdx[s*RB +: RB] = ra[s];
      srcBIdx[s*RB +: RB] = rb[s];
      dstIdx[s*RB +: RB]  = rd[s];
      slotClass[2*s +: 2] = cls[s];
    end
  end

  issue_group_checker #(.WIDTH(W), .REG_BITS(RB)) i_issue_group_checker (
    .clk(clk), .rstN(rstN), .slotValid(vld),
    .srcAIdx(srcAIdx), .srcAUse(useA), .srcBIdx(srcBIdx), .srcBUse(useB),
    .dstIdx(dstIdx), .dstWr(wr), .slotClass(slotClass),
    .prevLoadValid(plv), .prevLoadDst(pld), .issueCount(issueCount)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural reference: walk the slots, stop at the first reason to hold
  function automatic int model(output string why);
    int loads = 0;
    int divs  = 0;
    why = "R2";
    for (int s = 0; s < W; s++) begin
      if (!vld[s]) begin why = "R2"; return s; end
      if (plv && ((useA[s] && ra[s] != 0 && ra[s] == pld) ||
                  (useB[s] && rb[s] != 0 && rb[s] == pld))) begin
        why = "R5"; return s;
      end
      for (int j = 0; j < s; j++) begin
        if (wr[j] && rd[j] != 0 &&
            ((useA[s] && ra[s] == rd[j]) || (useB[s] && rb[s] == rd[j]))) begin
          why = "R3"; return s;
        end
      end
      if (cls[s] == 2'd1 && loads > 0) begin why = "R6"; return s; end
      if (cls[s] == 2'd3 && divs > 0)  begin why = "R7"; return s; end
      if (cls[s] == 2'd1) loads++;
      if (cls[s] == 2'd3) divs++;
    end
    return W;
  endfunction

  task automatic clearGroup();
    vld = '0; useA = '0; useB = '0; wr = '0; plv = 1'b0; pld = '0;
    for (int s = 0; s < W; s++) begin
      ra[s] = '0; rb[s] = '0; rd[s] = '0; cls[s] = 2'd0;
    end
  endtask

  // Distinct registers, all ALU, all valid: a clean group
  task automatic cleanGroup();
    clearGroup();
    vld = '1; useA = '1; useB = '1; wr = '1;
    for (int s = 0; s < W; s++) begin
      ra[s] = RB'(10 + s); rb[s] = RB'(20 + s); rd[s] = RB'(1 + s);
    end
  endtask

  task automatic check(string tag, int exp);
    checks++;
    if (int'(issueCount) != exp) begin
      fails++;
      $display("FAIL %s: issueCount=%0d expected=%0d at %0t", tag, issueCount, exp, $time);
    end
  endtask

  // Called at a falling edge with inputs set; checks after the next rising edge
  task automatic step(string tagIn);
    string why;
    int exp;
    exp = model(why);
    @(negedge clk);
    check(tagIn != "" ? tagIn : why, exp);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    string why;
    clearGroup();
    @(negedge clk);
    cleanGroup();
    repeat (2) @(negedge clk);
    check("R1", 0);                     // R1: held at 0 in reset despite a clean group
    rstN = 1'b1;

    step("R1");                         // R1: clean group, all four after one edge
    step("R2");                         // R2: full count, repeated

    cleanGroup(); vld[2] = 1'b0; step("R2");   // R2: invalid slot 2 -> 2
    cleanGroup(); vld[0] = 1'b0; step("R2");   // R2: invalid slot 0 -> 0

    cleanGroup(); rb[3] = rd[0]; step("R3");   // R3: slot 3 src B on slot 0 dst -> 3
    cleanGroup(); ra[1] = rd[0]; step("R3");   // R3: slot 1 on slot 0 -> 1

    cleanGroup(); ra[1] = rd[0]; wr[0] = 1'b0; step("R4");   // R4: no write flag -> 4
    cleanGroup(); ra[2] = rd[1]; useA[2] = 1'b0; step("R4"); // R4: no use flag -> 4
    cleanGroup(); rd[0] = '0; ra[1] = '0; step("R4");        // R4: register 0 -> 4

    cleanGroup(); plv = 1'b1; pld = ra[0]; step("R5");       // R5: slot 0 blocked -> 0
    cleanGroup(); plv = 1'b1; pld = rb[2]; step("R5");       // R5: slot 2 blocked -> 2
    cleanGroup(); plv = 1'b0; pld = ra[0]; step("R5");       // R5: no load pending -> 4

    cleanGroup(); cls[1] = 2'd1; cls[3] = 2'd1; step("R6");  // R6: second load at 3 -> 3
    cleanGroup(); cls[0] = 2'd3; cls[1] = 2'd3; step("R7");  // R7: second divide -> 1
    cleanGroup(); for (int s = 0; s < W; s++) cls[s] = 2'd2;
    step("R7");                                              // R7: four stores -> 4

    cleanGroup(); cls[0] = 2'd3; cls[1] = 2'd3; ra[1] = rd[0];
    plv = 1'b1; pld = 5'd31; step("R8");                     // R8: slot 0 still goes -> 1

    for (int n = 0; n < 3000; n++) begin
      clearGroup();
      for (int s = 0; s < W; s++) begin
        vld[s]  = ($urandom_range(0, 9) != 0);
        useA[s] = $urandom_range(0, 1) == 1;
        useB[s] = $urandom_range(0, 1) == 1;
        wr[s]   = $urandom_range(0, 1) == 1;
        ra[s]   = RB'($urandom_range(0, 5));
        rb[s]   = RB'($urandom_range(0, 5));
        rd[s]   = RB'($urandom_range(0, 5));
        cls[s]  = 2'($urandom_range(0, 3));
      end
      plv = $urandom_range(0, 2) == 0;
      pld = RB'($urandom_range(0, 5));
      step("");
    end

    clearGroup();
    rstN = 1'b0;
    @(negedge clk);
    check("R1", 0);                     // R1: asynchronous return to 0
    void'(model(why));
    finishRun();
  end

endmodule